// File: doc/BRIEF.md
# Power-Good and Thermal Flag Controller

This block decides when a boost regulator may report its output as good, and when the die is hot enough that the regulator must stop. The regulator's state machine reports three things: a one-cycle strobe when soft-start completes, a level that is high while a fault is being handled, and a level that is high while the switch current limit is engaged. A slow tick timebase and an unsigned die-temperature code, in whole degrees Celsius, complete the inputs. The outputs are an active-high power-good level and a thermal-shutdown request.

Power-good is armed by a clean soft-start and disarmed by any fault. Once disarmed it stays disarmed until the next soft-start strobe. While armed, two early warnings can hold it low without disarming it. The first is an overload timer that counts ticks while the current limit stays engaged. The second is a warm-die flag with separate set and release thresholds. A second hysteretic comparator, with higher thresholds, drives the shutdown request on its own. Every threshold is a parameter. Each output follows its inputs with one register stage.

Top module: `pwr_good_thermal_ctrl`

## Requirements
- R1: After reset, power-good and the shutdown request are both low.
- R2: A soft-start strobe sampled while no fault is active arms power-good. If no warning is active, power-good is high from the following cycle.
- R3: The overload timer adds one for each tick sampled while the current-limit flag is high. On the edge that samples the OVL_TICKS-th such tick (default 64), power-good goes low. Cycles without a tick do not advance the timer.
- R4: Any sampled cycle with the current-limit flag low returns the timer to zero. A fresh run of OVL_TICKS ticks is then needed, and power-good returns high once the overload warning is gone while armed.
- R5: A temperature strictly above WARN_ON (default 120) pulls power-good low one cycle later. It stays low until a temperature strictly below WARN_OFF (default 100) is sampled, and it rises one cycle after that if still armed.
- R6: A temperature equal to WARN_ON does not raise the warning, and a temperature equal to WARN_OFF does not release it.
- R7: A sampled fault flag drives power-good low on the next cycle. When the fault clears, power-good stays low until another soft-start strobe arrives.
- R8: A soft-start strobe sampled in the same cycle as an active fault is ignored, and power-good remains low afterwards.
- R9: The shutdown request rises one cycle after a temperature strictly above SHUT_ON (default 150) and falls one cycle after a temperature strictly below SHUT_OFF (default 130). Values exactly at SHUT_ON or SHUT_OFF leave it unchanged.
- R10: The overload timer saturates at OVL_TICKS and never wraps. Power-good stays low for as long as the current limit is held, however many ticks pass.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ss_done | input | 1 | One-cycle strobe: soft-start completed |
| fault_act | input | 1 | High while a regulator fault is active |
| ilim_act | input | 1 | High while the current limit is engaged |
| tick | input | 1 | Timebase pulse for the overload timer |
| die_temp | input | TEMP_W (8) | Unsigned die temperature in degrees Celsius |
| pgood | output | 1 | Power-good, active high |
| tshut_req | output | 1 | Thermal-shutdown request |

## Verification
A soft-start strobe and an active fault can land in the same cycle. The fault must win, and the strobe is lost rather than held over. The bench drives both for one cycle, then clears the fault. It then checks that power-good is still low, and that it only rises after a later lone strobe. In the same way, the shutdown comparator and the warm-die comparator can both switch on one sample. The bench steps the temperature across both set points in a single move and checks the two outputs on the following cycle.

// File: rtl/pgt_pkg.sv
package pgt_pkg;

    typedef struct packed {
        logic armed;
    } pg_state_t;

    // Next value of a hysteretic flag: set above the upper mark, clear below the lower.
    function automatic logic hyst_next(input logic cur, input logic above_hi, input logic below_lo);
        logic nxt;
        if (cur) nxt = !below_lo;
        else     nxt = above_hi;
        return nxt;
    endfunction

endpackage

// File: rtl/pgt_ovl_timer.sv
module pgt_ovl_timer #(
    parameter int OVL_TICKS = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ilim_act,
    input  logic tick,
    output logic ovl_warn
);
    localparam int CW = $clog2(OVL_TICKS + 1);
    localparam logic [CW-1:0] LIMIT = CW'(OVL_TICKS);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } ovl_state_t;

    ovl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!ilim_act)
            st_d.cnt = '0;
        else if (tick && (st_q.cnt != LIMIT))
            st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ovl_warn = (st_q.cnt == LIMIT);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LIMIT); // R10
    AST_OVL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !ilim_act |=> (st_q.cnt == '0)); // R4
    AST_OVL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ilim_act && !tick) |=> $stable(st_q.cnt)); // R3

endmodule

// File: rtl/pgt_temp_hyst.sv
module pgt_temp_hyst #(
    parameter int TEMP_W = 8,
    parameter int SET_ABOVE = 120,
    parameter int CLR_BELOW = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TEMP_W-1:0] temp,
    output logic              flag
);
    import pgt_pkg::*;

    localparam logic [TEMP_W-1:0] HI = TEMP_W'(SET_ABOVE);
    localparam logic [TEMP_W-1:0] LO = TEMP_W'(CLR_BELOW);

    logic flag_d, flag_q;

    always_comb begin
        flag_d = hyst_next(flag_q, temp > HI, temp < LO);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign flag = flag_q;

    AST_HYS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> ($past(temp) > HI)); // R5 R9
    AST_HYS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_q) |-> ($past(temp) < LO)); // R6 R9

endmodule

// File: rtl/pwr_good_thermal_ctrl.sv
module pwr_good_thermal_ctrl #(
    parameter int TEMP_W    = 8,
    parameter int OVL_TICKS = 64,
    parameter int WARN_ON   = 120,
    parameter int WARN_OFF  = 100,
    parameter int SHUT_ON   = 150,
    parameter int SHUT_OFF  = 130
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ss_done,
    input  logic              fault_act,
    input  logic              ilim_act,
    input  logic              tick,
    input  logic [TEMP_W-1:0] die_temp,
    output logic              pgood,
    output logic              tshut_req
);
    import pgt_pkg::*;

    logic ovl_warn, warm_warn;
    pg_state_t st_d, st_q;

    pgt_ovl_timer #(.OVL_TICKS(OVL_TICKS)) u_ovl (
        .clk(clk), .rst_n(rst_n), .ilim_act(ilim_act), .tick(tick), .ovl_warn(ovl_warn)
    );

    pgt_temp_hyst #(.TEMP_W(TEMP_W), .SET_ABOVE(WARN_ON), .CLR_BELOW(WARN_OFF)) u_warm (
        .clk(clk), .rst_n(rst_n), .temp(die_temp), .flag(warm_warn)
    );

    pgt_temp_hyst #(.TEMP_W(TEMP_W), .SET_ABOVE(SHUT_ON), .CLR_BELOW(SHUT_OFF)) u_shut (
        .clk(clk), .rst_n(rst_n), .temp(die_temp), .flag(tshut_req)
    );

    always_comb begin
        st_d = st_q;
        if (fault_act)
            st_d.armed = 1'b0;
        else if (ss_done)
            st_d.armed = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pgood = st_q.armed && !warm_warn && !ovl_warn;

    AST_FAULT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        fault_act |=> !pgood); // R7
    AST_ARM_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.armed) |-> ($past(ss_done) && !$past(fault_act))); // R8
    AST_HOT_NOT_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
        tshut_req |-> !pgood); // R9

endmodule

// File: tb/pwr_good_thermal_ctrl_test.sv
`timescale 1ns/1ps
module pwr_good_thermal_ctrl_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ss_done = 1'b0, fault_act = 1'b0, ilim_act = 1'b0, tick = 1'b0;
    logic [7:0] die_temp = 8'd25;
    logic pgood, tshut_req;
    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    pwr_good_thermal_ctrl uut (
        .clk(clk), .rst_n(rst_n), .ss_done(ss_done), .fault_act(fault_act),
        .ilim_act(ilim_act), .tick(tick), .die_temp(die_temp),
        .pgood(pgood), .tshut_req(tshut_req)
    );

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic chk(input logic got, input logic exp, input string what);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", what, got, exp);
        end
    endtask

    task automatic arm();
        ss_done = 1'b1; step(); ss_done = 1'b0;
    endtask

    task automatic t_reset();
        chk(pgood, 1'b0, "R1 pgood after reset");
        chk(tshut_req, 1'b0, "R1 tshut after reset");
    endtask

    task automatic t_start();
        step(3);
        chk(pgood, 1'b0, "R2 pgood before strobe");
        arm();
        chk(pgood, 1'b1, "R2 pgood after strobe");
    endtask

    task automatic t_overload();
        ilim_act = 1'b1; tick = 1'b0;
        step(10);
        chk(pgood, 1'b1, "R3 no ticks no count");
        tick = 1'b1;
        step(63);
        chk(pgood, 1'b1, "R3 pgood after 63 ticks");
        step();
        chk(pgood, 1'b0, "R3 pgood low at 64 ticks");
        ilim_act = 1'b0; step();
        chk(pgood, 1'b1, "R4 pgood back after limit drop");
        ilim_act = 1'b1; step(40);
        ilim_act = 1'b0; step();
        ilim_act = 1'b1; step(63);
        chk(pgood, 1'b1, "R4 timer restarted from zero");
        step();
        chk(pgood, 1'b0, "R4 fresh run trips");
        ilim_act = 1'b0; tick = 1'b0; step();
    endtask

    task automatic t_saturate();
        logic seen_high;
        seen_high = 1'b0;
        ilim_act = 1'b1; tick = 1'b1;
        step(64);
        for (int i = 0; i < 200; i++) begin
            step();
            if (pgood) seen_high = 1'b1;
        end
        chk(seen_high, 1'b0, "R10 no wrap while limit held");
        ilim_act = 1'b0; tick = 1'b0; step();
        chk(pgood, 1'b1, "R10 recovers after release");
    endtask

    task automatic t_warm();
        die_temp = 8'd120; step();
        chk(pgood, 1'b1, "R6 exactly 120 no warning");
        die_temp = 8'd121; step();
        chk(pgood, 1'b0, "R5 above 120 drops");
        die_temp = 8'd110; step();
        chk(pgood, 1'b0, "R5 inside band stays low");
        die_temp = 8'd100; step();
        chk(pgood, 1'b0, "R6 exactly 100 no release");
        die_temp = 8'd99; step();
        chk(pgood, 1'b1, "R5 below 100 restores");
    endtask

    task automatic t_shutdown();
        die_temp = 8'd150; step();
        chk(tshut_req, 1'b0, "R9 exactly 150 no request");
        chk(pgood, 1'b0, "R5 150 is warm");
        die_temp = 8'd151; step();
        chk(tshut_req, 1'b1, "R9 above 150 requests");
        die_temp = 8'd130; step();
        chk(tshut_req, 1'b1, "R9 exactly 130 holds");
        die_temp = 8'd129; step();
        chk(tshut_req, 1'b0, "R9 below 130 clears");
        chk(pgood, 1'b0, "R5 warm still held at 129");
        die_temp = 8'd25; step();
        chk(pgood, 1'b1, "R5 cool again");
        die_temp = 8'd200; step();
        chk(tshut_req, 1'b1, "R9 jump sets shutdown");
        chk(pgood, 1'b0, "R5 jump sets warm same cycle");
        die_temp = 8'd25; step();
        chk(tshut_req, 1'b0, "R9 jump down clears");
        chk(pgood, 1'b1, "R5 jump down releases");
    endtask

    task automatic t_fault();
        fault_act = 1'b1; step();
        chk(pgood, 1'b0, "R7 fault drops pgood");
        fault_act = 1'b0; step(3);
        chk(pgood, 1'b0, "R7 stays low after fault clears");
        arm();
        chk(pgood, 1'b1, "R7 new strobe rearms");
    endtask

    task automatic t_conflict();
        fault_act = 1'b1; ss_done = 1'b1; step();
        chk(pgood, 1'b0, "R8 strobe with fault");
        fault_act = 1'b0; ss_done = 1'b0; step(2);
        chk(pgood, 1'b0, "R8 strobe was ignored");
        arm();
        chk(pgood, 1'b1, "R8 lone strobe arms");
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        step(2);
        t_reset();
        rst_n = 1'b1;
        step();
        t_reset();
        t_start();
        t_overload();
        t_saturate();
        t_warm();
        t_shutdown();
        t_fault();
        t_conflict();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule